// File: doc/BRIEF.md
# Entropy Continuous Health Tester

This block sits between a raw physical noise source and a downstream conditioner. It receives one raw random bit each time `bit_valid` is high and runs two continuous health tests on the stream. The first test watches for runs of identical bits. The second counts the ones in consecutive fixed-size windows and rejects a window whose majority value is too frequent. Accepted bits are packed into bytes, most significant bit first. A byte is forwarded on a valid/ready output only if every bit in it arrived while both tests were passing.

Any failure sets a sticky flag for the test that tripped and drops the byte being built. The block then ignores the source until `clear_error` is pulsed, and a status LED level goes low. A pulse marks each sixteenth forwarded byte, so a conditioner that consumes fixed blocks can find their boundaries. Both cutoffs have parameter defaults. A cutoff input of zero selects the default, and any other value overrides it at run time.

Top module: `entropy_health_monitor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `byte_valid`, `block_done`, `rct_fail`, `apt_fail` and `overflow` are 0 and `status_led` is 1.
- R2: Accepted bits are packed MSB first: the first accepted bit becomes `byte_data[7]`. `byte_valid` is high right after the clock edge that takes the eighth bit.
- R3: The run counter restarts at 1 whenever a bit differs from the previous one, and the first bit after reset or clear starts a run of 1. If a run reaches cutoff+1 identical bits, `rct_fail` is set on the edge that takes that bit. A run of exactly cutoff bits passes.
- R4: The window test runs over windows of APT_WINDOW (512) accepted bits. On the edge that takes the last bit of a window, `apt_fail` is set if max(ones, 512 − ones) exceeds the cutoff. A count equal to the cutoff passes.
- R5: A cutoff input of 0 selects the parameter default: 32 for the run test and 400 for the window test.
- R6: The partial byte that holds a failing bit is discarded. While either flag is set, bits are ignored and no new byte is loaded.
- R7: A one-cycle `clear_error` clears both fail flags and `overflow`. It also restarts the run counter, the window, the partial byte and the block count. A bit offered in the clear cycle is ignored.
- R8: While `byte_valid` is high and `byte_ready` is low, `byte_valid` stays high and `byte_data` stays stable.
- R9: If a byte completes while the output register holds an unaccepted byte, the new byte is dropped and the sticky `overflow` flag is set.
- R10: `block_done` is a one-cycle pulse in the cycle after every sixteenth handshake counted since reset or clear.
- R11: `status_led` goes low one cycle after either fail flag is set, and returns high one cycle after both flags are clear.
- R12: Cycles with `bit_valid` low do not affect packing or either test, whatever the value of `bit_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Raw bit strobe |
| bit_in | input | 1 | Raw random bit |
| clear_error | input | 1 | Clears the fail flags and restarts the tests |
| rct_cutoff | input | RCT_CUT_W (6) | Run-length cutoff, 0 selects the default |
| apt_cutoff | input | APT_CUT_W (10) | Window majority cutoff, 0 selects the default |
| byte_ready | input | 1 | Downstream accepts the byte |
| byte_valid | output | 1 | Output byte available |
| byte_data | output | 8 | Output byte |
| block_done | output | 1 | Pulse after each sixteenth forwarded byte |
| rct_fail | output | 1 | Sticky run-test failure |
| apt_fail | output | 1 | Sticky window-test failure |
| overflow | output | 1 | Sticky lost-byte flag |
| status_led | output | 1 | High while healthy, low while failed |

## Verification
The bench changes every input 1 ns after a rising edge and reads the results 1 ns after the next edge. This is the point where the fail flags, `overflow` and a new `byte_valid` become visible for the bit that edge took. `status_led` is read one cycle later, because it follows the registered flags. A monitor running 3 ns after each edge logs every handshake that the following edge completes. It checks that `block_done` appears one edge after the sixteenth handshake. Each window test also checks the flag after the 511th bit, to confirm the verdict arrives exactly at the window's last bit.

// File: rtl/ehm_pkg.sv
package ehm_pkg;

  localparam int BYTE_W = 8;

  // one raw bit offered to the tests in a given cycle
  typedef struct packed {
    logic take;
    logic value;
  } sample_t;

endpackage

// File: rtl/ehm_rct.sv
module ehm_rct
  import ehm_pkg::*;
#(
  parameter int CUT_W   = 6,
  parameter int DEF_CUT = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  sample_t          smp,
  input  logic [CUT_W-1:0] cut_in,
  output logic             fail_now
);

  localparam int RUN_W = CUT_W + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

  logic             have_prev;
  logic             prev_bit;
  logic [RUN_W-1:0] run_len;
  logic [RUN_W-1:0] run_nxt;
  logic [CUT_W-1:0] cut_eff;

  always_comb cut_eff = (cut_in == '0) ? CUT_W'(DEF_CUT) : cut_in;

  always_comb begin
    if (!have_prev || (smp.value != prev_bit)) run_nxt = RUN_ONE;
    else if (run_len == RUN_MAX)               run_nxt = RUN_MAX;
    else                                       run_nxt = run_len + RUN_ONE;
  end

  assign fail_now = smp.take && (run_nxt > {1'b0, cut_eff});

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      have_prev <= 1'b0;
      prev_bit  <= 1'b0;
      run_len   <= '0;
    end else if (smp.take) begin
      have_prev <= 1'b1;
      prev_bit  <= smp.value;
      run_len   <= run_nxt;
    end
  end

  // R3
  rct_run_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (smp.take && !restart && have_prev && (smp.value != prev_bit)) |=> (run_len == RUN_ONE));

  // R7
  rct_clear_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!have_prev && run_len == '0));

endmodule

// File: rtl/ehm_apt.sv
module ehm_apt
  import ehm_pkg::*;
#(
  parameter int WINDOW  = 512,
  parameter int CUT_W   = 10,
  parameter int DEF_CUT = 400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  sample_t          smp,
  input  logic [CUT_W-1:0] cut_in,
  output logic             fail_now
);

  localparam int IDX_W = $clog2(WINDOW);
  localparam logic [CUT_W-1:0] WIN_C = CUT_W'(WINDOW);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WINDOW - 1);

  logic [IDX_W-1:0] idx;
  logic [CUT_W-1:0] ones;
  logic [CUT_W-1:0] ones_tot;
  logic [CUT_W-1:0] zeros_tot;
  logic [CUT_W-1:0] most;
  logic [CUT_W-1:0] cut_eff;
  logic             win_end;

  always_comb begin
    cut_eff   = (cut_in == '0) ? CUT_W'(DEF_CUT) : cut_in;
    win_end   = (idx == LAST_IDX);
    ones_tot  = ones + CUT_W'(smp.value);
    zeros_tot = WIN_C - ones_tot;
    most      = (ones_tot > zeros_tot) ? ones_tot : zeros_tot;
  end

  assign fail_now = smp.take && win_end && (most > cut_eff);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      idx  <= '0;
      ones <= '0;
    end else if (smp.take) begin
      if (win_end) begin
        idx  <= '0;
        ones <= '0;
      end else begin
        idx  <= idx + IDX_W'(1);
        ones <= ones_tot;
      end
    end
  end

  // R4
  apt_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(ones) <= 32'(idx)));

  // R4
  apt_window_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (smp.take && win_end && !restart) |=> (idx == '0 && ones == '0));

endmodule

// File: rtl/ehm_packer.sv
module ehm_packer
  import ehm_pkg::*;
#(
  parameter int BLOCK_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  sample_t           smp,
  input  logic              drop,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              block_done,
  output logic              lost_now
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam int BLK_W = $clog2(BLOCK_BYTES);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(BLOCK_BYTES - 1);

  logic [BYTE_W-2:0] sreg;
  logic [CNT_W-1:0]  cnt;
  logic [BLK_W-1:0]  blk;
  logic              accept;
  logic              complete;

  always_comb begin
    accept   = out_valid && out_ready;
    complete = smp.take && !drop && (cnt == LAST_BIT);
    lost_now = complete && out_valid && !accept;
  end

  // bit assembly
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      sreg <= '0;
    end else if (smp.take) begin
      sreg <= {sreg[BYTE_W-3:0], smp.value};
      if (drop || cnt == LAST_BIT) cnt <= '0;
      else                         cnt <= cnt + CNT_W'(1);
    end
  end

  // output register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (complete && (!out_valid || accept)) begin
      out_valid <= 1'b1;
      out_data  <= {sreg, smp.value};
    end else if (accept) begin
      out_valid <= 1'b0;
    end
  end

  // block boundary
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      blk        <= '0;
      block_done <= 1'b0;
    end else if (accept) begin
      block_done <= (blk == LAST_BLK);
      blk        <= (blk == LAST_BLK) ? '0 : blk + BLK_W'(1);
    end else begin
      block_done <= 1'b0;
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10
  block_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    block_done |-> $past(accept));

  // R10
  block_single_chk: assert property (@(posedge clk) disable iff (rst)
    block_done |=> !block_done);

endmodule

// File: rtl/entropy_health_monitor.sv
module entropy_health_monitor
  import ehm_pkg::*;
#(
  parameter int RCT_CUT_W   = 6,
  parameter int RCT_DEFAULT = 32,
  parameter int APT_WINDOW  = 512,
  parameter int APT_CUT_W   = $clog2(APT_WINDOW + 1),
  parameter int APT_DEFAULT = 400,
  parameter int BLOCK_BYTES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_valid,
  input  logic                 bit_in,
  input  logic                 clear_error,
  input  logic [RCT_CUT_W-1:0] rct_cutoff,
  input  logic [APT_CUT_W-1:0] apt_cutoff,
  input  logic                 byte_ready,
  output logic                 byte_valid,
  output logic [BYTE_W-1:0]    byte_data,
  output logic                 block_done,
  output logic                 rct_fail,
  output logic                 apt_fail,
  output logic                 overflow,
  output logic                 status_led
);

  sample_t smp;
  logic    rct_now;
  logic    apt_now;
  logic    lost_now;

  always_comb begin
    smp.take  = bit_valid && !clear_error && !rct_fail && !apt_fail;
    smp.value = bit_in;
  end

  ehm_rct #(
    .CUT_W   (RCT_CUT_W),
    .DEF_CUT (RCT_DEFAULT)
  ) u_rct (
    .clk      (clk),
    .rst      (rst),
    .restart  (clear_error),
    .smp      (smp),
    .cut_in   (rct_cutoff),
    .fail_now (rct_now)
  );

  ehm_apt #(
    .WINDOW  (APT_WINDOW),
    .CUT_W   (APT_CUT_W),
    .DEF_CUT (APT_DEFAULT)
  ) u_apt (
    .clk      (clk),
    .rst      (rst),
    .restart  (clear_error),
    .smp      (smp),
    .cut_in   (apt_cutoff),
    .fail_now (apt_now)
  );

  ehm_packer #(
    .BLOCK_BYTES (BLOCK_BYTES)
  ) u_pack (
    .clk        (clk),
    .rst        (rst),
    .restart    (clear_error),
    .smp        (smp),
    .drop       (rct_now || apt_now),
    .out_ready  (byte_ready),
    .out_valid  (byte_valid),
    .out_data   (byte_data),
    .block_done (block_done),
    .lost_now   (lost_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rct_fail   <= 1'b0;
      apt_fail   <= 1'b0;
      overflow   <= 1'b0;
      status_led <= 1'b1;
    end else begin
      status_led <= !(rct_fail || apt_fail);
      if (clear_error) begin
        rct_fail <= 1'b0;
        apt_fail <= 1'b0;
        overflow <= 1'b0;
      end else begin
        rct_fail <= rct_fail || rct_now;
        apt_fail <= apt_fail || apt_now;
        overflow <= overflow || lost_now;
      end
    end
  end

  // R3
  rct_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (rct_fail && !clear_error) |=> rct_fail);

  // R6
  no_load_in_error_chk: assert property (@(posedge clk) disable iff (rst)
    ((rct_fail || apt_fail) && !byte_valid) |=> !byte_valid);

  // R11
  led_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (rct_fail || apt_fail) |=> !status_led);

  // R7
  clear_flags_chk: assert property (@(posedge clk) disable iff (rst)
    clear_error |=> (!rct_fail && !apt_fail && !overflow));

endmodule

// File: tb/entropy_health_monitor_test.sv
module entropy_health_monitor_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic       clear_error = 1'b0;
  logic [5:0] rct_cut = '0;
  logic [9:0] apt_cut = '0;
  logic       rdy = 1'b1;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       block_done;
  logic       rct_fail;
  logic       apt_fail;
  logic       overflow;
  logic       status_led;

  int tests = 0;
  int fails = 0;
  int rx_cnt = 0;
  int hs_cnt = 0;
  int bd_cnt = 0;
  int bd_bad = 0;
  logic [7:0] rx [0:2047];
  bit done = 1'b0;

  always #4 clk = ~clk;

  entropy_health_monitor uut (
    .clk         (clk),
    .rst         (rst),
    .bit_valid   (bit_valid),
    .bit_in      (bit_in),
    .clear_error (clear_error),
    .rct_cutoff  (rct_cut),
    .apt_cutoff  (apt_cut),
    .byte_ready  (rdy),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .block_done  (block_done),
    .rct_fail    (rct_fail),
    .apt_fail    (apt_fail),
    .overflow    (overflow),
    .status_led  (status_led)
  );

  // handshake and block monitor, 3 ns after each edge
  always @(posedge clk) begin
    #3;
    if (!rst) begin
      if (block_done) begin
        bd_cnt++;
        if (hs_cnt == 0 || (hs_cnt % 16) != 0) bd_bad++;
      end
      if (byte_valid && rdy) begin
        if (rx_cnt < 2048) rx[rx_cnt] = byte_data;
        rx_cnt++;
        hs_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // all tasks start and end 1 ns after a rising edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    bit_valid = 1'b1;
    bit_in    = b;
    step();
    bit_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int j = 7; j >= 0; j--) send_bit(v[j]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      bit_valid = 1'b0;
      bit_in    = ~bit_in;
      step();
    end
  endtask

  task automatic pulse_clear();
    clear_error = 1'b1;
    bit_valid   = 1'b1;
    bit_in      = 1'b1;
    step();
    clear_error = 1'b0;
    bit_valid   = 1'b0;
    hs_cnt      = 0;
  endtask

  // one window with k ones spread evenly
  task automatic run_window(input int k, input logic [9:0] cut, input bit exp_fail);
    int start;
    apt_cut = cut;
    rct_cut = '0;
    pulse_clear();
    start = rx_cnt;
    for (int i = 0; i < 512; i++) begin
      send_bit(1'(((i + 1) * k) / 512 - (i * k) / 512));
      if (i == 510) chk(apt_fail == 1'b0, "R4 no verdict before window end", int'(apt_fail), 0);
    end
    chk(apt_fail == exp_fail, "R4 window verdict", int'(apt_fail), int'(exp_fail));
    chk(rct_fail == 1'b0, "R4 run test quiet", int'(rct_fail), 0);
    idle(3);
    chk((rx_cnt - start) == (exp_fail ? 63 : 64), "R6 bytes forwarded in window",
        rx_cnt - start, exp_fail ? 63 : 64);
  endtask

  initial begin
    int base;
    int bad;
    repeat (4) @(posedge clk);
    #1;
    // R1 during reset
    chk(byte_valid == 0 && rct_fail == 0 && apt_fail == 0 && overflow == 0, "R1 outputs in reset",
        int'({byte_valid, rct_fail, apt_fail, overflow}), 0);
    chk(status_led == 1'b1, "R1 led in reset", int'(status_led), 1);
    rst = 1'b0;
    step();
    chk(byte_valid == 0 && block_done == 0 && rct_fail == 0 && apt_fail == 0 && overflow == 0,
        "R1 outputs after reset", int'({byte_valid, block_done, rct_fail, apt_fail, overflow}), 0);
    chk(status_led == 1'b1, "R1 led after reset", int'(status_led), 1);

    // R2 R12 R10: every byte value, gap cycles with toggling bit_in
    for (int v = 0; v < 256; v++) begin
      for (int j = 7; j >= 0; j--) begin
        send_bit(v[j]);
        idle(1);
      end
    end
    idle(4);
    chk(rx_cnt == 256, "R12 byte count over sweep", rx_cnt, 256);
    bad = 0;
    for (int i = 0; i < 256; i++) begin
      if (rx[i] != 8'(i)) bad++;
    end
    chk(bad == 0, "R2 sweep bytes MSB first", bad, 0);
    chk(rct_fail == 0 && apt_fail == 0, "R12 sweep no failure", int'({rct_fail, apt_fail}), 0);
    chk(bd_cnt == 16, "R10 block pulses", bd_cnt, 16);
    chk(bd_bad == 0, "R10 pulse placement", bd_bad, 0);

    // R3 run cutoff of 5
    rct_cut = 6'd5;
    pulse_clear();
    base = rx_cnt;
    send_bit(1'b0);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    send_bit(1'b0);
    chk(rct_fail == 1'b0, "R3 run equal to cutoff passes", int'(rct_fail), 0);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    chk(rct_fail == 1'b0, "R3 five after change", int'(rct_fail), 0);
    send_bit(1'b1);
    chk(rct_fail == 1'b1, "R3 run over cutoff fails", int'(rct_fail), 1);
    chk(status_led == 1'b1, "R11 led one cycle late", int'(status_led), 1);
    idle(1);
    chk(status_led == 1'b0, "R11 led low", int'(status_led), 0);
    chk(rx_cnt == base + 1 && rx[base] == 8'h7D, "R2 first byte before failure",
        int'(rx[base]), 8'h7D);
    // R6 ignored while failed
    for (int i = 0; i < 16; i++) send_bit(1'(i % 2));
    idle(2);
    chk(rx_cnt == base + 1, "R6 no bytes while failed", rx_cnt - base, 1);
    chk(rct_fail == 1'b1 && apt_fail == 1'b0, "R6 flags held", int'({rct_fail, apt_fail}), 2);
    // R7 clear restarts the partial byte
    pulse_clear();
    chk(rct_fail == 0 && apt_fail == 0, "R7 flags cleared", int'({rct_fail, apt_fail}), 0);
    idle(1);
    chk(status_led == 1'b1, "R11 led back high", int'(status_led), 1);
    send_byte(8'hA3);
    idle(2);
    chk(rx_cnt == base + 2 && rx[base + 1] == 8'hA3, "R7 byte aligned after clear",
        int'(rx[base + 1]), 8'hA3);

    // R5 default run cutoff of 32
    rct_cut = '0;
    pulse_clear();
    for (int i = 0; i < 32; i++) send_bit(1'b1);
    chk(rct_fail == 1'b0, "R5 default run of 32 passes", int'(rct_fail), 0);
    send_bit(1'b1);
    chk(rct_fail == 1'b1, "R5 default run of 33 fails", int'(rct_fail), 1);

    // R4 R5 window test boundaries
    run_window(300, 10'd300, 1'b0);
    run_window(301, 10'd300, 1'b1);
    run_window(211, 10'd300, 1'b1);
    run_window(212, 10'd300, 1'b0);
    run_window(400, 10'd0, 1'b0);
    run_window(401, 10'd0, 1'b1);

    // R8 R9 hold and overflow
    rct_cut = '0;
    apt_cut = '0;
    pulse_clear();
    rdy = 1'b0;
    base = rx_cnt;
    send_byte(8'h5C);
    chk(byte_valid == 1'b1 && byte_data == 8'h5C, "R2 valid after eighth bit", int'(byte_data), 8'h5C);
    idle(3);
    chk(byte_valid == 1'b1 && byte_data == 8'h5C, "R8 held while not ready", int'(byte_data), 8'h5C);
    chk(overflow == 1'b0, "R9 no overflow yet", int'(overflow), 0);
    send_byte(8'hC5);
    chk(overflow == 1'b1, "R9 overflow on lost byte", int'(overflow), 1);
    chk(byte_data == 8'h5C, "R8 data kept over lost byte", int'(byte_data), 8'h5C);
    rdy = 1'b1;
    idle(1);
    chk(byte_valid == 1'b0, "R8 valid drops after accept", int'(byte_valid), 0);
    send_byte(8'h3A);
    idle(2);
    chk(rx_cnt == base + 2 && rx[base] == 8'h5C && rx[base + 1] == 8'h3A, "R9 lost byte absent",
        int'(rx[base + 1]), 8'h3A);
    pulse_clear();
    chk(overflow == 1'b0, "R7 overflow cleared", int'(overflow), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule